// File: doc/BRIEF.md
# Page Write Collector with Wrapping Offset

This block sits between a serial-memory protocol engine and a nonvolatile array. During a write transfer the protocol engine first hands over the start address. It then streams the data bytes one at a time. The block keeps those bytes in a one-page latch, with a flag per slot that records which slots were filled. The byte offset advances inside the page and wraps at the page end, so the page row never changes within a transfer.

When the engine reports the end of the transfer, the block copies every filled slot into the array through a plain write port. This only happens if at least one byte arrived. The block then keeps its busy flag high for a fixed, parameterised number of clocks that models the self-timed programming interval. A new transfer that begins before the end of the current one throws away whatever was collected. A protect input stops the array from changing.

Byte input uses a valid/ready handshake. A byte is taken on a clock edge where `byte_valid` and `byte_ready` are both high. `byte_ready` is low for the whole busy interval, and a held byte waits with its data stable. The control strobes and the memory port have no handshake.

Top module: `page_write_collector`

## Requirements
- R1: After reset, `busy` is low, `byte_ready` is high and `mem_we` is low.
- R2: An accepted byte is stored at the current in-page offset, and the offset then increases by one. `load_addr` bits [5:0] give the starting offset, and bits [14:6] give the page row, which stays fixed for the transfer.
- R3: The offset past 63 is 0 on the same row. When more than 64 bytes arrive, the later bytes replace the earlier ones in the same slots.
- R4: Only slots that received a byte are written. Slot i is written in busy cycle i (counting from 0), to address {row, i}, so the writes come in ascending offset order. Slots that received no byte are not written.
- R5: `busy` rises on the clock after an `end_xfer` strobe that follows at least one accepted byte. It then stays high for exactly WRITE_CYCLES clocks (100 by default).
- R6: While `protect` is high, `mem_we` stays low. The busy interval still runs in full.
- R7: A `begin_xfer` strobe before `end_xfer` discards every collected byte, and nothing from it is ever written.
- R8: While `busy` is high, `byte_ready` is low, and `begin_xfer`, `end_xfer`, `addr_load` and offered bytes have no effect.
- R9: An `end_xfer` with no collected bytes writes nothing and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| begin_xfer | input | 1 | Transfer start strobe; clears the latch when idle |
| addr_load | input | 1 | Load strobe for `load_addr` |
| load_addr | input | 15 | Start address: row [14:6], offset [5:0] |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Block can take a byte (low while busy) |
| byte_data | input | 8 | Data byte |
| end_xfer | input | 1 | Transfer end strobe; triggers the commit |
| protect | input | 1 | Array write protect, active high |
| busy | output | 1 | Write cycle in progress |
| mem_we | output | 1 | Array write enable, one byte per clock |
| mem_addr | output | 15 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench targets these cases:
- A start offset of 62 with four bytes. A design without the wrap would spill onto the next row, which the scoreboard sees as wrong addresses.
- 66 bytes, which must overwrite slots 0 and 1. A design that kept the first bytes, or that wrote more than 64 bytes, produces a data mismatch or an unexpected write.
- An address load and an offered byte while busy, the byte coming in the last busy cycle. A design that accepted them would move the row mid-commit, or keep a byte that a later bare `end_xfer` would write.
- An abort by a new start, the protect input, and an empty end. Each of these must produce no write at all. The busy length is counted exactly, to catch off-by-one timers.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PROG = 1'b1
  } pwc_state_e;
endpackage

// File: rtl/pwc_offset_ctr.sv
module pwc_offset_ctr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     step_i,
  output logic [ADDR_W-PAGE_W-1:0] row_o,
  output logic [PAGE_W-1:0]        off_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_o <= '0;
      off_o <= '0;
    end else if (load_i) begin
      row_o <= addr_i[ADDR_W-1:PAGE_W];
      off_o <= addr_i[PAGE_W-1:0];
    end else if (step_i) begin
      off_o <= off_o + PAGE_W'(1);  // low bits only: wraps inside the page
    end
  end

  // R2/R3: a step moves only the in-page offset, modulo the page size
  p_step_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_i) && !$past(load_i)) |->
      (row_o == $past(row_o)) && (off_o == PAGE_W'($past(off_o) + 1'b1)));
endmodule

// File: rtl/pwc_page_latch.sv
module pwc_page_latch #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_filled_o,
  output logic              any_o
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  filled_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g]   <= '0;
        filled_q[g] <= 1'b0;
      end else begin
        if (hit) slot_q[g] <= wr_data_i;
        // a new byte wins over a clear in the same cycle
        if (hit)        filled_q[g] <= 1'b1;
        else if (clr_i) filled_q[g] <= 1'b0;
      end
    end
  end

  assign rd_data_o   = slot_q[rd_idx_i];
  assign rd_filled_o = filled_q[rd_idx_i];
  assign any_o       = |filled_q;

  // R2: the slot that took a byte is marked as filled
  p_slot_marked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i) |-> filled_q[$past(wr_idx_i)]);
endmodule

// File: rtl/pwc_cycle_timer.sv
module pwc_cycle_timer
  import pwc_pkg::*;
#(
  parameter int WRITE_CYCLES = 100,
  parameter int PAGE_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_i,
  input  logic              have_data_i,
  output logic              busy_o,
  output logic              scan_en_o,
  output logic [PAGE_W-1:0] scan_idx_o,
  output logic              done_o
);
  localparam int SLOTS = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  pwc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (end_i && have_data_i) begin
          state_q <= ST_PROG;
          cnt_q   <= '0;
        end
        ST_PROG: if (cnt_q == LAST) begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == ST_PROG);
  assign scan_en_o  = busy_o && (cnt_q < CNT_W'(SLOTS));
  assign scan_idx_o = cnt_q[PAGE_W-1:0];
  assign done_o     = busy_o && (cnt_q == LAST);

  // R5: the busy interval is only entered from an end strobe with data
  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(end_i) && $past(have_data_i)));
  // R5: the busy interval ends only after the full count
  p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/page_write_collector.sv
module page_write_collector #(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 6,
  parameter int WRITE_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_xfer,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              end_xfer,
  input  logic              protect,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic              accept, load_ok, clr;
  logic [ROW_W-1:0]  row;
  logic [PAGE_W-1:0] off, scan_idx;
  logic              scan_en, done, any_filled, slot_filled;
  logic [DATA_W-1:0] slot_data;

  assign byte_ready = !busy;
  assign accept     = byte_valid && byte_ready;
  assign load_ok    = addr_load && !busy;
  assign clr        = (begin_xfer && !busy) || done;

  pwc_offset_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_off (
    .clk(clk), .rst_n(rst_n), .load_i(load_ok), .addr_i(load_addr),
    .step_i(accept), .row_o(row), .off_o(off)
  );

  pwc_page_latch #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(accept),
    .wr_idx_i(off), .wr_data_i(byte_data), .rd_idx_i(scan_idx),
    .rd_data_o(slot_data), .rd_filled_o(slot_filled), .any_o(any_filled)
  );

  pwc_cycle_timer #(.WRITE_CYCLES(WRITE_CYCLES), .PAGE_W(PAGE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .end_i(end_xfer), .have_data_i(any_filled),
    .busy_o(busy), .scan_en_o(scan_en), .scan_idx_o(scan_idx), .done_o(done)
  );

  assign mem_we    = scan_en && slot_filled && !protect;
  assign mem_addr  = {row, scan_idx};
  assign mem_wdata = slot_data;

  // R4: array writes happen only inside the busy interval
  p_write_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R8: the page row cannot move during a commit
  p_row_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (row == $past(row)));
  // R6: protect blocks every array write
  p_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    protect |-> !mem_we);
endmodule

// File: tb/page_write_collector_tb.sv
module page_write_collector_tb;
  localparam int WRC = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        begin_xfer = 1'b0, addr_load = 1'b0, byte_valid = 1'b0;
  logic        end_xfer = 1'b0, protect = 1'b0;
  logic [14:0] load_addr = '0;
  logic [7:0]  byte_data = '0;
  logic        byte_ready, busy, mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #4 clk = ~clk;

  page_write_collector u_dut (
    .clk(clk), .rst_n(rst_n), .begin_xfer(begin_xfer), .addr_load(addr_load),
    .load_addr(load_addr), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .end_xfer(end_xfer), .protect(protect),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  logic [22:0] exp_q[$];

  // model of the page latch
  logic [8:0] m_row;
  int         m_off;
  logic [7:0] m_data [64];
  bit         m_fill [64];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_tag, " unexpected write"}, {9'd0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        chk(e == {mem_addr, mem_wdata}, {cur_tag, " write"},
            {9'd0, mem_addr, mem_wdata}, {9'd0, e});
      end
    end
  end

  task automatic clr_model();
    for (int i = 0; i < 64; i++) m_fill[i] = 0;
  endtask

  task automatic do_begin();
    begin_xfer = 1'b1;
    @(negedge clk) begin_xfer = 1'b0;
    clr_model();
  endtask

  task automatic do_load(input logic [14:0] a);
    addr_load = 1'b1; load_addr = a;
    @(negedge clk) addr_load = 1'b0;
    m_row = a[14:6]; m_off = int'(a[5:0]);
  endtask

  task automatic do_byte(input logic [7:0] d);
    byte_valid = 1'b1; byte_data = d;
    @(negedge clk) byte_valid = 1'b0;
    m_data[m_off] = d; m_fill[m_off] = 1; m_off = (m_off + 1) % 64;
  endtask

  task automatic do_end(input bit wp, input bit poke, input string tag);
    bit any = 0;
    int n = 0;
    cur_tag = tag;
    for (int i = 0; i < 64; i++) if (m_fill[i]) any = 1;
    if (any && !wp)
      for (int i = 0; i < 64; i++)
        if (m_fill[i]) exp_q.push_back({m_row, 6'(i), m_data[i]});
    end_xfer = 1'b1; protect = wp;
    @(negedge clk) end_xfer = 1'b0;
    chk(busy == any, {tag, " busy after end (R5/R9)"}, 32'(busy), 32'(any));
    while (busy && n < WRC + 10) begin
      if (n == 2) chk(byte_ready == 1'b0, "R8 ready low while busy", 32'(byte_ready), 0);
      if (poke && n == 3) begin
        addr_load = 1'b1; load_addr = 15'h7FC0; begin_xfer = 1'b1; end_xfer = 1'b1;
      end else if (poke && n == WRC - 1) begin
        byte_valid = 1'b1; byte_data = 8'hEE;
      end else begin
        addr_load = 1'b0; begin_xfer = 1'b0; end_xfer = 1'b0; byte_valid = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    addr_load = 1'b0; begin_xfer = 1'b0; end_xfer = 1'b0; byte_valid = 1'b0;
    protect = 1'b0;
    if (any) begin
      chk(n == WRC, {tag, " busy length R5"}, n, WRC);
      clr_model();
    end else begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, {tag, " stays idle R9"}, 32'(busy), 0);
    end
    chk(exp_q.size() == 0, {tag, " all writes seen R4"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    clr_model();
    m_row = '0; m_off = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(byte_ready == 1'b1, "R1 ready", 32'(byte_ready), 1);
    chk(mem_we == 1'b0, "R1 we", 32'(mem_we), 0);

    // R2/R4: partial page at an inner offset
    do_begin(); do_load({9'd10, 6'd5});
    do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
    do_end(1'b0, 1'b0, "R2 partial");

    // R3: wrap from the page end to slot 0 of the same row
    do_begin(); do_load({9'd3, 6'd62});
    for (int i = 0; i < 4; i++) do_byte(8'(8'h50 + i));
    do_end(1'b0, 1'b0, "R3 wrap");

    // R3 overflow of 66 bytes, with R8 pokes during busy
    do_begin(); do_load({9'd200, 6'd0});
    for (int i = 0; i < 66; i++) do_byte(8'(i + 1));
    do_end(1'b0, 1'b1, "R3 overflow");
    // R8: a bare end now must not commit anything poked while busy
    do_end(1'b0, 1'b0, "R8 poke ignored");

    // R6: protect blocks writes but busy still runs
    do_begin(); do_load({9'd7, 6'd20});
    do_byte(8'h11); do_byte(8'h22);
    do_end(1'b1, 1'b0, "R6 protect");

    // R7: new start discards collected bytes
    do_begin(); do_load({9'd9, 6'd0});
    do_byte(8'h31); do_byte(8'h32); do_byte(8'h33);
    do_begin();
    do_end(1'b0, 1'b0, "R7 abort");
    do_load({9'd9, 6'd40}); do_byte(8'h77);
    do_end(1'b0, 1'b0, "R7 after abort");

    // R9: end without any byte
    do_begin(); do_load({9'd1, 6'd1});
    do_end(1'b0, 1'b0, "R9 empty");

    summary();
    $finish;
  end
endmodule